// File: doc/BRIEF.md
# March X Self-Test Controller for Parallel Tag-Storage Ways

This block sits beside the tag memories of a set-associative cache. When reset is released it runs a March X test over every way at once. One address sequence, one write pattern and one write strobe fan out to all ways. The read data of each way comes back after one cycle of SRAM latency. It is checked by the same per-way equality comparators that serve tag lookup. During the test the comparators see the expected background pattern in place of a request tag. Any mismatch sets that way's bit in an error vector, and the bit stays set.

While the test runs, the block holds a stall output high and keeps the lookup port not-ready, so normal cache traffic waits. The last March element reads back zeros from every location, so the ways are already cleared when the test ends and need no separate clear pass. After that the done flag rises, the write strobes stay quiet, and the address port and comparators pass to normal lookups. A lookup returns a per-way hit vector one cycle after it is accepted. The done flag and the error vector keep their values until the next reset.

Top module: `tag_mbist_top`

## Requirements
- R1: The test starts on its own after reset release. The reset is synchronised through two stages, and one idle cycle follows. `bist_done_o` rises exactly 6*DEPTH+4 clock edges after `rst_n` is released. `stall_o` is high and `bist_done_o` is low from reset until that edge.
- R2: All ways are written in lockstep. `mem_we_o` is either all zeros or all ones. `mem_addr_o` and `mem_wdata_o` are shared by every way.
- R3: The elements run in this order. First, zeros are written to every address in ascending order. Second, in ascending order, each address is read with zero expected and then written with all ones. Third, in descending order, each address is read with all ones expected and then written with zero. Last, every address is read in ascending order with zero expected. Each way therefore sees DEPTH all-ones writes at ascending addresses and 2*DEPTH all-zero writes, and the last DEPTH of those are at descending addresses.
- R4: When `bist_done_o` rises, every location of every fault-free way holds zero.
- R5: Read data is compared in the cycle after the read. Bit w of `bist_err_o` is set when way w returns data different from the expected pattern, and it never clears before reset. Stuck-at-one and stuck-at-zero cells are both detected, including cells at the first and last address. Only the faulty ways are flagged.
- R6: After `bist_done_o` rises, the block issues no further writes.
- R7: While the test runs, `lkp_ready_o` is low. A lookup request presented then is ignored, and `hit_valid_o` stays low.
- R8: Once set, `bist_done_o` and `bist_err_o` hold their values until the next reset.
- R9: After the test, a lookup accepted on a clock edge (`lkp_valid_i` and `lkp_ready_o` both high) sets `hit_valid_o` for the following cycle. In that cycle, bit w of `hit_o` is 1 exactly when way w holds `lkp_tag_i` at `lkp_index_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lkp_valid_i | input | 1 | Lookup request valid |
| lkp_index_i | input | $clog2(DEPTH) | Lookup set index |
| lkp_tag_i | input | TAG_W | Lookup request tag |
| lkp_ready_o | output | 1 | Lookup port ready (high only after the test) |
| hit_valid_o | output | 1 | Hit vector valid, one cycle after acceptance |
| hit_o | output | WAYS | Per-way tag match, bit index = way index |
| mem_addr_o | output | $clog2(DEPTH) | Shared address to all tag ways |
| mem_we_o | output | WAYS | Per-way write strobe |
| mem_wdata_o | output | TAG_W | Shared write data |
| mem_rdata_i | input | WAYS*TAG_W | Read data, way w at bits [w*TAG_W +: TAG_W], one-cycle latency |
| stall_o | output | 1 | Blocks normal cache accesses while the test runs |
| bist_done_o | output | 1 | Test completed |
| bist_err_o | output | WAYS | Sticky per-way fault flag, bit index = way index |

## Verification
The bench runs the test against a fault-free memory that was preloaded with a non-zero background. This shows whether the zero-fill and the final state are correct, and whether the write trace follows the March X order. Single stuck-at-one and stuck-at-zero cells are then placed in different ways at the first, middle and last addresses. A stuck-at-one cell is caught by the ascending read-zero. A stuck-at-zero cell is caught only by the descending read-one. Together these show that the comparator is enabled in the right cycle, expects the right pattern and flags the right way. A run with two faulty ways separates per-way capture from a shared flag. Lookups after each run show that the comparators return to tag matching.

// File: rtl/tag_mbist_pkg.sv
package tag_mbist_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_FILL  = 3'd1,
    PH_UP    = 3'd2,
    PH_DN    = 3'd3,
    PH_RD    = 3'd4,
    PH_FLUSH = 3'd5,
    PH_DONE  = 3'd6
  } mb_phase_e;
endpackage

// File: rtl/tag_mbist_rst_sync.sv
module tag_mbist_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/tag_mbist_seq.sv
module tag_mbist_seq
  import tag_mbist_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] addr_o,
  output logic          we_o,
  output logic          wbit_o,
  output logic          cmp_en_o,
  output logic          cmp_bit_o,
  output logic          done_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  mb_phase_e     phase_q, phase_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          wr_step_q, wr_step_d;
  logic          rd_now, exp_now;

  // step decode
  always_comb begin
    rd_now  = ((phase_q == PH_UP || phase_q == PH_DN) && !wr_step_q) || (phase_q == PH_RD);
    exp_now = (phase_q == PH_DN);
    we_o    = (phase_q == PH_FILL) || ((phase_q == PH_UP || phase_q == PH_DN) && wr_step_q);
    wbit_o  = (phase_q == PH_UP);
    addr_o  = addr_q;
    done_o  = (phase_q == PH_DONE);
  end

  // next state
  always_comb begin
    phase_d   = phase_q;
    addr_d    = addr_q;
    wr_step_d = wr_step_q;
    unique case (phase_q)
      PH_IDLE: begin
        phase_d = PH_FILL;
        addr_d  = '0;
      end
      PH_FILL: begin
        if (addr_q == LAST) begin
          phase_d   = PH_UP;
          addr_d    = '0;
          wr_step_d = 1'b0;
        end else begin
          addr_d = addr_q + 1'b1;
        end
      end
      PH_UP: begin
        if (!wr_step_q) begin
          wr_step_d = 1'b1;
        end else begin
          wr_step_d = 1'b0;
          if (addr_q == LAST) begin
            phase_d = PH_DN;
          end else begin
            addr_d = addr_q + 1'b1;
          end
        end
      end
      PH_DN: begin
        if (!wr_step_q) begin
          wr_step_d = 1'b1;
        end else begin
          wr_step_d = 1'b0;
          if (addr_q == '0) begin
            phase_d = PH_RD;
          end else begin
            addr_d = addr_q - 1'b1;
          end
        end
      end
      PH_RD: begin
        if (addr_q == LAST) begin
          phase_d = PH_FLUSH;
          addr_d  = '0;
        end else begin
          addr_d = addr_q + 1'b1;
        end
      end
      PH_FLUSH: phase_d = PH_DONE;
      PH_DONE:  phase_d = PH_DONE;
      default:  phase_d = PH_DONE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      addr_q    <= '0;
      wr_step_q <= 1'b0;
      cmp_en_o  <= 1'b0;
      cmp_bit_o <= 1'b0;
    end else begin
      phase_q   <= phase_d;
      addr_q    <= addr_d;
      wr_step_q <= wr_step_d;
      cmp_en_o  <= rd_now;
      cmp_bit_o <= exp_now;
    end
  end
endmodule

// File: rtl/tag_mbist_cmp.sv
module tag_mbist_cmp #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned TAG_W = 8
) (
  input  logic [WAYS*TAG_W-1:0] rdata_i,
  input  logic [TAG_W-1:0]      key_i,
  output logic [WAYS-1:0]       eq_o
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign eq_o[w] = (rdata_i[w*TAG_W +: TAG_W] == key_i);
  end
endmodule

// File: rtl/tag_mbist_err.sv
module tag_mbist_err #(
  parameter int unsigned WAYS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmp_en_i,
  input  logic [WAYS-1:0] eq_i,
  output logic [WAYS-1:0] err_o
);
  logic [WAYS-1:0] err_d;

  always_comb begin
    err_d = err_o;
    if (cmp_en_i) err_d = err_o | ~eq_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_o <= '0;
    else if (cmp_en_i) err_o <= err_d;
  end
endmodule

// File: rtl/tag_mbist_top.sv
module tag_mbist_top #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned TAG_W = 8,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  lkp_valid_i,
  input  logic [AW-1:0]         lkp_index_i,
  input  logic [TAG_W-1:0]      lkp_tag_i,
  output logic                  lkp_ready_o,
  output logic                  hit_valid_o,
  output logic [WAYS-1:0]       hit_o,
  output logic [AW-1:0]         mem_addr_o,
  output logic [WAYS-1:0]       mem_we_o,
  output logic [TAG_W-1:0]      mem_wdata_o,
  input  logic [WAYS*TAG_W-1:0] mem_rdata_i,
  output logic                  stall_o,
  output logic                  bist_done_o,
  output logic [WAYS-1:0]       bist_err_o
);
  logic            rst_sync_n;
  logic [AW-1:0]   seq_addr;
  logic            seq_we, seq_wbit, cmp_en, cmp_bit, done;
  logic [TAG_W-1:0] key, lkp_tag_q;
  logic [WAYS-1:0] eq;
  logic            accept, hit_vld_q;

  tag_mbist_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tag_mbist_seq #(.DEPTH(DEPTH)) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .addr_o    (seq_addr),
    .we_o      (seq_we),
    .wbit_o    (seq_wbit),
    .cmp_en_o  (cmp_en),
    .cmp_bit_o (cmp_bit),
    .done_o    (done)
  );

  // comparators shared between self-test and lookup
  assign key = done ? lkp_tag_q : {TAG_W{cmp_bit}};

  tag_mbist_cmp #(.WAYS(WAYS), .TAG_W(TAG_W)) u_cmp (
    .rdata_i (mem_rdata_i),
    .key_i   (key),
    .eq_o    (eq)
  );

  tag_mbist_err #(.WAYS(WAYS)) u_err (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cmp_en_i (cmp_en),
    .eq_i     (eq),
    .err_o    (bist_err_o)
  );

  assign accept = lkp_valid_i && done;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      lkp_tag_q <= '0;
      hit_vld_q <= 1'b0;
    end else begin
      hit_vld_q <= accept;
      if (accept) lkp_tag_q <= lkp_tag_i;
    end
  end

  always_comb begin
    mem_addr_o  = done ? lkp_index_i : seq_addr;
    mem_we_o    = {WAYS{seq_we}};
    mem_wdata_o = {TAG_W{seq_wbit}};
    lkp_ready_o = done;
    stall_o     = !done;
    bist_done_o = done;
    hit_valid_o = hit_vld_q;
    hit_o       = eq & {WAYS{hit_vld_q}};
  end
endmodule

// File: rtl/tag_mbist_chk.sv
module tag_mbist_chk #(
  parameter int unsigned WAYS = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bist_done_o,
  input logic [WAYS-1:0] bist_err_o,
  input logic [WAYS-1:0] mem_we_o,
  input logic            hit_valid_o,
  input logic            stall_o,
  input logic            lkp_ready_o
);
  a_r8_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bist_done_o |=> bist_done_o);

  a_r8_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bist_done_o |=> $stable(bist_err_o));

  a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !bist_done_o |=> ((bist_err_o & $past(bist_err_o)) == $past(bist_err_o)));

  a_r6_no_write_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    bist_done_o |-> (mem_we_o == '0));

  a_r2_we_lockstep: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o == '0) || (mem_we_o == '1));

  a_r7_no_hit_in_test: assert property (@(posedge clk) disable iff (!rst_n)
    !bist_done_o |-> !hit_valid_o);

  a_r7_not_ready_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> !lkp_ready_o);
endmodule

bind tag_mbist_top tag_mbist_chk #(.WAYS(WAYS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bist_done_o (bist_done_o),
  .bist_err_o  (bist_err_o),
  .mem_we_o    (mem_we_o),
  .hit_valid_o (hit_valid_o),
  .stall_o     (stall_o),
  .lkp_ready_o (lkp_ready_o)
);

// File: tb/tag_mbist_top_tb.sv
module tag_mbist_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WAYS  = 4;
  localparam int DEPTH = 16;
  localparam int TW    = 8;
  localparam int AW    = $clog2(DEPTH);

  logic                 clk, rst_n;
  logic                 lkp_valid;
  logic [AW-1:0]        lkp_index;
  logic [TW-1:0]        lkp_tag;
  logic                 lkp_ready, hit_valid, stall, done;
  logic [WAYS-1:0]      hit, we, err;
  logic [AW-1:0]        addr;
  logic [TW-1:0]        wdata;
  logic [WAYS*TW-1:0]   rdata;

  int total, bad;

  tag_mbist_top #(.WAYS(WAYS), .DEPTH(DEPTH), .TAG_W(TW)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .lkp_valid_i (lkp_valid),
    .lkp_index_i (lkp_index),
    .lkp_tag_i   (lkp_tag),
    .lkp_ready_o (lkp_ready),
    .hit_valid_o (hit_valid),
    .hit_o       (hit),
    .mem_addr_o  (addr),
    .mem_we_o    (we),
    .mem_wdata_o (wdata),
    .mem_rdata_i (rdata),
    .stall_o     (stall),
    .bist_done_o (done),
    .bist_err_o  (err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural tag ways with injectable stuck-at cells
  logic [TW-1:0] mem [WAYS][DEPTH];
  logic          f_on   [WAYS];
  logic [AW-1:0] f_addr [WAYS];
  int            f_bit  [WAYS];
  logic          f_val  [WAYS];

  int            n_one, n_zero, bad_we;
  logic [AW-1:0] one_addr  [DEPTH];
  logic [AW-1:0] zero_addr [2*DEPTH];

  function automatic logic [TW-1:0] stored(int w, logic [AW-1:0] a, logic [TW-1:0] d);
    logic [TW-1:0] r;
    r = d;
    if (f_on[w] && f_addr[w] == a) r[f_bit[w]] = f_val[w];
    return r;
  endfunction

  always @(posedge clk) begin
    for (int w = 0; w < WAYS; w++) begin
      rdata[w*TW +: TW] <= mem[w][addr];
      if (we[w]) mem[w][addr] <= stored(w, addr, wdata);
    end
    if (we != '0 && we != '1) bad_we <= bad_we + 1;
    if (we[0]) begin
      if (wdata == '1) begin
        if (n_one < DEPTH) one_addr[n_one] <= addr;
        n_one <= n_one + 1;
      end else begin
        if (n_zero < 2*DEPTH) zero_addr[n_zero] <= addr;
        n_zero <= n_zero + 1;
      end
    end
  end

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_faults();
    for (int w = 0; w < WAYS; w++) begin
      f_on[w] = 1'b0; f_addr[w] = '0; f_bit[w] = 0; f_val[w] = 1'b0;
    end
  endtask

  // reset, then run the test with lookups hammering the port (R1, R7)
  task automatic run_test(output int cycles);
    int stall_bad, ready_bad, hit_bad;
    rst_n = 1'b0;
    lkp_valid = 1'b0;
    repeat (3) @(negedge clk);
    for (int w = 0; w < WAYS; w++)
      for (int a = 0; a < DEPTH; a++) mem[w][a] = stored(w, AW'(a), 8'hA5);
    n_one = 0; n_zero = 0; bad_we = 0;
    check("R1", "done low in reset", {31'd0, done}, 32'd0);
    check("R1", "stall high in reset", {31'd0, stall}, 32'd1);
    check("R5", "err clear in reset", {28'd0, err}, 32'd0);
    lkp_valid = 1'b1; lkp_index = '0; lkp_tag = '0;
    rst_n = 1'b1;
    cycles = 0; stall_bad = 0; ready_bad = 0; hit_bad = 0;
    while (!done && cycles < 2000) begin
      @(posedge clk);
      cycles++;
      @(negedge clk);
      if (!done) begin
        if (!stall) stall_bad++;
        if (lkp_ready) ready_bad++;
        if (hit_valid) hit_bad++;
      end
    end
    lkp_valid = 1'b0;
    check("R1", "stall low during test", stall_bad, 0);
    check("R7", "ready high during test", ready_bad, 0);
    check("R7", "hit_valid during test", hit_bad, 0);
    check("R1", "cycles to done", cycles, 6*DEPTH+4);
  endtask

  task automatic lookup(input logic [AW-1:0] idx, input logic [TW-1:0] tag, input string req);
    logic [WAYS-1:0] exp;
    for (int w = 0; w < WAYS; w++) exp[w] = (mem[w][idx] == tag);
    @(negedge clk);
    lkp_valid = 1'b1; lkp_index = idx; lkp_tag = tag;
    @(posedge clk);
    @(negedge clk);
    lkp_valid = 1'b0;
    check(req, "hit_valid after accept", {31'd0, hit_valid}, 32'd1);
    check(req, "hit vector", {28'd0, hit}, {28'd0, exp});
    @(negedge clk);
    check(req, "hit_valid one cycle", {31'd0, hit_valid}, 32'd0);
  endtask

  task automatic t_clean();
    int cyc, nz, mono, desc, w_before;
    logic [WAYS-1:0] err0;
    clear_faults();
    run_test(cyc);
    check("R5", "no error on clean ways", {28'd0, err}, 32'd0);
    check("R2", "write strobes lockstep", bad_we, 0);
    check("R3", "ones writes", n_one, DEPTH);
    check("R3", "zero writes", n_zero, 2*DEPTH);
    mono = 0; desc = 0;
    for (int i = 0; i < DEPTH; i++) begin
      if (one_addr[i] != AW'(i)) mono++;
      if (zero_addr[i] != AW'(i)) mono++;
      if (zero_addr[DEPTH+i] != AW'(DEPTH-1-i)) desc++;
    end
    check("R3", "ascending fill and w1 order", mono, 0);
    check("R3", "descending w0 order", desc, 0);
    nz = 0;
    for (int w = 0; w < WAYS; w++)
      for (int a = 0; a < DEPTH; a++) if (mem[w][a] != '0) nz++;
    check("R4", "nonzero cells at end", nz, 0);
    w_before = n_one + n_zero;
    err0 = err;
    lookup(AW'(3), 8'h00, "R9");
    lookup(AW'(DEPTH-1), 8'h3C, "R9");
    repeat (40) @(negedge clk);
    check("R6", "writes after done", n_one + n_zero, w_before);
    check("R8", "done holds", {31'd0, done}, 32'd1);
    check("R8", "err holds", {28'd0, err}, {28'd0, err0});
  endtask

  task automatic t_stuck1();
    int cyc;
    clear_faults();
    f_on[2] = 1'b1; f_addr[2] = AW'(5); f_bit[2] = 3; f_val[2] = 1'b1;
    run_test(cyc);
    check("R5", "stuck-at-1 way 2", {28'd0, err}, 32'h4);
    lookup(AW'(5), 8'h00, "R9");
    lookup(AW'(5), 8'h08, "R9");
  endtask

  task automatic t_stuck0();
    int cyc;
    clear_faults();
    f_on[0] = 1'b1; f_addr[0] = AW'(DEPTH-1); f_bit[0] = 0; f_val[0] = 1'b0;
    run_test(cyc);
    check("R5", "stuck-at-0 way 0 last addr", {28'd0, err}, 32'h1);
  endtask

  task automatic t_two_ways();
    int cyc;
    clear_faults();
    f_on[1] = 1'b1; f_addr[1] = AW'(0); f_bit[1] = 7; f_val[1] = 1'b1;
    f_on[3] = 1'b1; f_addr[3] = AW'(9); f_bit[3] = 4; f_val[3] = 1'b0;
    run_test(cyc);
    check("R5", "two faulty ways", {28'd0, err}, 32'hA);
    repeat (20) @(negedge clk);
    check("R8", "err held with faults", {28'd0, err}, 32'hA);
  endtask

  initial begin
    total = 0; bad = 0;
    rst_n = 1'b0;
    lkp_valid = 1'b0; lkp_index = '0; lkp_tag = '0;
    clear_faults();
    n_one = 0; n_zero = 0; bad_we = 0;
    t_clean();
    t_stuck1();
    t_stuck0();
    t_two_ways();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule